// File: doc/BRIEF.md
# Banked Pin-Change Interrupt Detector

This block watches a set of general input pins arranged in banks of eight and keeps one sticky interrupt flag per bank. The default is three banks and 24 pins. Bank 0 holds pins 7..0, bank 1 holds pins 15..8 and bank 2 holds pins 23..16. Each pin first passes through a level latch that is open while the clock is low. It then passes through a flop on the rising clock edge. After that it is gated by the pin's enable bit in its bank's mask register. A bank compares its masked, synchronized pin values with the values it stored on the previous cycle. Any difference, whether a rise or a fall, sets the bank's flag one cycle later.

The pins are sampled whatever drives them. Software can therefore raise an interrupt by writing a pin that is configured as an output. Each bank also gives a combinational wake output that needs no clock. It is high while any enabled pin differs from the value last captured by its synchronizer, so it can wake a sleeping system whose clock has stopped. A flag stays set until the host writes a one to its clear bit. A change that arrives in the same cycle as the clear wins over the clear. The per-bank request output is the flag gated by a bank enable input.

Each bank is a two-state machine. ST_QUIET means no flag is pending and ST_PENDING means the flag is set. The transition QUIET→PENDING is taken on a detected change. PENDING→QUIET is taken on a clear with no change in the same cycle. PENDING→PENDING holds the flag otherwise, and QUIET→QUIET is taken when nothing changes.

Top module: `pcint_group_det`

## Requirements
- R1: After reset every flag, request and wake output is 0 and every mask bit is 0, so toggling any pin before a mask write sets no flag.
- R2: If an enabled pin rises while the clock is low before rising edge k, its bank flag is still 0 after edge k and reads 1 after edge k+1.
- R3: A falling edge on an enabled pin sets its bank flag with the same two-edge timing as a rise.
- R4: A pin whose mask bit is 0 never sets a flag and never raises wake, however often it toggles.
- R5: Pin i belongs to bank i/8 only. A change there sets flag bit i/8 and leaves the other flags unchanged.
- R6: A set flag stays 1 until its bit in flag_clr_i is 1 at a rising edge. If no change occurs in that cycle, the flag reads 0 after that edge.
- R7: When a change is detected in the same cycle as the clear for that bank, the flag stays 1.
- R8: irq_o bit b equals flag_o bit b ANDed with bank_en_i bit b.
- R9: wake_o bit b is high, with no clock edge needed, whenever an enabled pin of bank b differs from the value its synchronizer last captured.
- R10: When mask_we_i bit b is 1 at a rising edge, bank b's mask becomes mask_wdata_i. Bit j of the mask enables pin 8*b+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 24 | Raw pin levels, bank b on bits 8b+7..8b |
| mask_we_i | input | 3 | Per-bank mask write strobe |
| mask_wdata_i | input | 8 | Mask value written to the selected banks |
| flag_clr_i | input | 3 | Write-one-to-clear per bank flag |
| bank_en_i | input | 3 | Per-bank request enable |
| flag_o | output | 3 | Sticky per-bank change flags |
| irq_o | output | 3 | Enabled per-bank interrupt requests |
| wake_o | output | 3 | Combinational masked change indication per bank |

## Verification
A wrong stored previous value shows at the ports as a flag that sets with no pin activity, or that misses a real toggle, two rising edges after the disturbance. A corrupted mask or synchronizer value shows as a wrong wake level in the very next low clock phase. A bank machine stuck in the wrong state shows as a flag that will not clear, or that drops on its own, one edge after the clear window. The reference model compares flags, requests and wake on every clock, so any of these faults is reported within two cycles of its cause.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_PENDING = 1'b1
    } bank_st_t;
endpackage

// File: rtl/pcint_pin_sync.sv
module pcint_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] lat_q;

    // Open while clk is low; holds across the rising edge.
    always_latch begin
        if (!clk) lat_q <= d_i;
    end

    always_ff @(posedge clk) begin
        q_o <= lat_q;
    end
endmodule

// File: rtl/pcint_bank.sv
module pcint_bank
    import pcint_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] sync_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         clr_i,
    output logic         flag_o,
    output logic         wake_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] masked;
    logic         change;
    bank_st_t     state_q, state_nx;

    assign masked = sync_i & mask_q;
    assign change = |(masked ^ prev_q);
    assign wake_o = |((raw_i ^ sync_i) & mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= masked;
            if (mask_we_i) mask_q <= mask_wdata_i;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_QUIET:   if (change) state_nx = ST_PENDING;
            ST_PENDING: if (clr_i && !change) state_nx = ST_QUIET;
            default:    state_nx = ST_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == ST_PENDING);
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> flag_o);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !change) |=> !flag_o);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_i && !change) |=> !flag_o);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (change && clr_i) |=> flag_o);
endmodule

// File: rtl/pcint_group_det.sv
module pcint_group_det #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    localparam int NPINS    = NUM_BANKS * BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_i,
    input  logic [NUM_BANKS-1:0] mask_we_i,
    input  logic [BANK_W-1:0]    mask_wdata_i,
    input  logic [NUM_BANKS-1:0] flag_clr_i,
    input  logic [NUM_BANKS-1:0] bank_en_i,
    output logic [NUM_BANKS-1:0] flag_o,
    output logic [NUM_BANKS-1:0] irq_o,
    output logic [NUM_BANKS-1:0] wake_o
);
    logic [NPINS-1:0] sync_w;

    pcint_pin_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .d_i (pin_i),
        .q_o (sync_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcint_bank #(.W(BANK_W)) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .raw_i        (pin_i[b*BANK_W +: BANK_W]),
            .sync_i       (sync_w[b*BANK_W +: BANK_W]),
            .mask_we_i    (mask_we_i[b]),
            .mask_wdata_i (mask_wdata_i),
            .clr_i        (flag_clr_i[b]),
            .flag_o       (flag_o[b]),
            .wake_o       (wake_o[b])
        );
    end

    assign irq_o = flag_o & bank_en_i;

    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o[0] && !$past(flag_o[0]) && rst_n) |-> !irq_o[0]);
endmodule

// File: tb/tb_pcint_group_det.sv
module tb_pcint_group_det;
    localparam int NB = 3;
    localparam int BW = 8;
    localparam int NP = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic [NB-1:0] mask_we = '0;
    logic [BW-1:0] mask_wdata = '0;
    logic [NB-1:0] flag_clr = '0;
    logic [NB-1:0] bank_en = 3'b101;
    logic [NB-1:0] flag_o, irq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcint_group_det dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .mask_we_i(mask_we),
        .mask_wdata_i(mask_wdata), .flag_clr_i(flag_clr), .bank_en_i(bank_en),
        .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    // Behavioural reference model
    logic [NP-1:0] m_sync;
    logic [NP-1:0] m_prev;
    logic [NP-1:0] m_mask;
    logic [NB-1:0] m_flag;

    always @(posedge clk) begin
        logic [NP-1:0] now_masked;
        now_masked = m_sync & m_mask;
        if (!rst_n) begin
            m_prev = '0;
            m_mask = '0;
            m_flag = '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                bit hit;
                hit = 0;
                for (int j = 0; j < BW; j++)
                    if (now_masked[b*BW+j] !== m_prev[b*BW+j]) hit = 1;
                m_flag[b] = hit || (m_flag[b] && !flag_clr[b]);
                if (mask_we[b]) m_mask[b*BW +: BW] = mask_wdata;
            end
            m_prev = now_masked;
        end
        m_sync = pin;
    end

    function automatic logic [NB-1:0] model_wake();
        logic [NB-1:0] w;
        for (int b = 0; b < NB; b++) begin
            w[b] = 0;
            for (int j = 0; j < BW; j++)
                if (m_mask[b*BW+j] && (pin[b*BW+j] !== m_sync[b*BW+j])) w[b] = 1;
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model flags", 32'(flag_o), 32'(m_flag));
            chk("R8 model irq", 32'(irq_o), 32'(m_flag & bank_en));
            #5;
            chk("R9 model wake", 32'(wake_o), 32'(model_wake()));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mask(input int b, input logic [7:0] v);
        mask_wdata = v;
        mask_we = '0;
        mask_we[b] = 1'b1;
        cyc(1);
        mask_we = '0;
    endtask

    task automatic clr(input int b);
        flag_clr = '0;
        flag_clr[b] = 1'b1;
        cyc(1);
        flag_clr = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 flags after reset", 32'(flag_o), 0);
        chk("R1 irq after reset", 32'(irq_o), 0);
        // masks are zero: toggles must not set anything
        pin[3] = 1'b1; pin[12] = 1'b1; pin[20] = 1'b1;
        cyc(1);
        chk("R1 wake with zero masks", 32'(wake_o), 0);
        cyc(3);
        chk("R1 no flag before mask write", 32'(flag_o), 0);
        pin = '0;
        cyc(3);

        // R10 mask writes
        wr_mask(0, 8'h08);
        wr_mask(1, 8'hFF);
        wr_mask(2, 8'h01);
        cyc(2);
        chk("R10 quiet after mask write", 32'(flag_o), 0);

        // R2 rising edge timing
        pin[3] = 1'b1;
        cyc(1);
        chk("R2 not yet set after first edge", 32'(flag_o), 0);
        cyc(1);
        chk("R2 set after second edge", 32'(flag_o), 3'b001);
        chk("R8 irq bank0 enabled", 32'(irq_o), 3'b001);

        // R6 sticky then clear
        cyc(4);
        chk("R6 flag sticky", 32'(flag_o), 3'b001);
        clr(0);
        chk("R6 flag cleared", 32'(flag_o), 0);

        // R3 falling edge
        pin[3] = 1'b0;
        cyc(1);
        chk("R3 not yet set", 32'(flag_o), 0);
        cyc(1);
        chk("R3 set on fall", 32'(flag_o), 3'b001);
        clr(0);

        // R4 masked-off pin in bank 0
        for (int k = 0; k < 4; k++) begin
            pin[2] = ~pin[2];
            cyc(2);
        end
        chk("R4 masked pin no flag", 32'(flag_o), 0);
        chk("R4 masked pin no wake", 32'(wake_o), 0);

        // R5 bank mapping, R8 disabled bank
        pin[9] = 1'b1;
        cyc(2);
        chk("R5 pin 9 sets bank1 only", 32'(flag_o), 3'b010);
        chk("R8 bank1 request gated", 32'(irq_o), 0);
        clr(1);
        chk("R5 bank1 cleared", 32'(flag_o), 0);

        // R10 mask bit j maps to pin 8b+j: pin 17 off, pin 16 on
        pin[17] = 1'b1;
        cyc(3);
        chk("R10 pin17 masked", 32'(flag_o), 0);
        pin[16] = 1'b1;
        cyc(2);
        chk("R10 pin16 enabled", 32'(flag_o), 3'b100);
        chk("R8 bank2 request", 32'(irq_o), 3'b100);

        // R7 set beats clear: flag already set, new change meets clear
        pin[16] = 1'b0;
        cyc(1);
        flag_clr = 3'b100;
        cyc(1);
        flag_clr = '0;
        chk("R7 set wins over clear", 32'(flag_o), 3'b100);
        clr(2);
        chk("R7 later clear works", 32'(flag_o), 0);

        // R9 wake without a clock edge
        cyc(1);
        #2 pin[3] = 1'b1;
        #1 chk("R9 wake rises in low phase", 32'(wake_o), 3'b001);
        cyc(1);
        chk("R9 wake drops after capture", 32'(wake_o), 0);
        cyc(2);
        clr(0);
        chk("R6 final clear", 32'(flag_o), 0);

        cyc(2);
        finish_run();
    end
endmodule